// File: doc/BRIEF.md
# Single-to-Brain-Float Narrowing Converter

This block narrows a 32-bit IEEE single-precision word into a 16-bit brain-float word (1 sign bit, 8 exponent bits, 7 fraction bits). The sign and the exponent keep their meaning. The fraction is cut from 23 bits to 7, and the 16 bits that are removed decide how the result is rounded. The rounding rule is picked on every transfer through a 2-bit mode input: chop toward zero, nearest with ties to even, or round-to-odd. Round-to-odd is the non-IEEE "jamming" rule, which keeps a later second rounding free of double-rounding error.

The classifier sorts each input into one of five categories, and each category is handled its own way. Zero stays zero. A subnormal becomes a zero with the same sign. A normal value goes through the rounder. An infinity stays an infinity. A NaN leaves as a quiet NaN. A normal value whose rounded magnitude would pass the largest finite value saturates to infinity with the input sign.

The converter has a single register stage. A word presented with its valid strobe produces the result, its valid strobe and two flags after the next rising clock edge. The flags are inexact and overflow.

Top module: `f32_to_bf16_conv`

The classifier categories, which select the output path, are:
- CLS_ZERO: exponent 0 and fraction 0.
- CLS_SUBN: exponent 0 and fraction nonzero.
- CLS_NORM: exponent 1 to 254.
- CLS_INF: exponent 255 and fraction 0.
- CLS_NAN: exponent 255 and fraction nonzero.

The category is fixed by the input word alone. There are no transitions between categories across cycles.

## Requirements
- R1: While in reset, and afterwards, out_valid equals the value in_valid had one clock edge earlier. After reset, out_valid, out_word, flag_inexact and flag_overflow are all 0.
- R2: Mode code 00 (chop) outputs input bits 31:16 unchanged for a normal input that does not overflow.
- R3: Mode code 01 (nearest-even) rounds to the nearer brain-float value. On an exact tie (discarded bits equal 0x8000) it picks the value whose fraction bit 0 is 0. A carry may ripple into the exponent.
- R4: Mode code 10 (odd) takes input bits 31:16 and forces bit 0 to 1 when any of the 16 discarded bits is 1. This mode never produces infinity from a finite input.
- R5: Mode code 11 gives the same results as code 01.
- R6: When a normal input rounds past 0x7F7F in magnitude, out_word is 0x7F80 or 0xFF80 (the sign follows bit 31), and flag_overflow and flag_inexact are both 1.
- R7: An input with exponent 255 and fraction 0 gives an infinity with the input sign, and both flags are 0.
- R8: An input with exponent 255 and a nonzero fraction gives {sign, 0xFF, 1, input bits 21:16}: always a quiet NaN and never an infinity. Both flags are 0.
- R9: An input with exponent 0 gives a zero with the input sign, whatever its fraction, and both flags are 0.
- R10: For a normal input, flag_inexact is 1 exactly when any of input bits 15:0 is 1. flag_overflow is 1 only for the case in R6.
- R11: In a cycle with in_valid low, out_word and both flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is valid this cycle |
| in_word | input | 32 | Single-precision operand |
| rnd_mode | input | 2 | Rounding rule: 00 chop, 01 nearest-even, 10 odd, 11 as 01 |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_word | output | 16 | Brain-float result |
| flag_inexact | output | 1 | Some discarded bit of a normal input was 1 |
| flag_overflow | output | 1 | A finite input rounded to infinity |

## Verification
Every result of this block is due at the first rising edge after the stimulus: the word, both flags and out_valid. The bench applies each input on a falling edge and reads the outputs on the next falling edge, so each value is sampled half a period after the edge that registers it. The hold behaviour (R11) is read one further falling edge later, after a cycle with the strobe low and a different word on the input. The latency of out_valid is checked at both edges of a single strobe pulse.

// File: rtl/f2b_pkg.sv
package f2b_pkg;

    typedef enum logic [1:0] {
        RM_TRUNC = 2'b00,
        RM_RNE   = 2'b01,
        RM_ODD   = 2'b10,
        RM_RSVD  = 2'b11
    } rnd_mode_e;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUBN,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } num_class_e;

endpackage

// File: rtl/f2b_classify.sv
module f2b_classify
    import f2b_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W-1:0]  exp_f,
    input  logic [FRAC_W-1:0] frac_f,
    output num_class_e        cls
);

    logic exp_min;
    logic exp_max;
    logic frac_nz;

    assign exp_min = (exp_f == '0);
    assign exp_max = (exp_f == '1);
    assign frac_nz = |frac_f;

    always_comb begin
        unique case ({exp_min, exp_max})
            2'b10:   cls = frac_nz ? CLS_SUBN : CLS_ZERO;
            2'b01:   cls = frac_nz ? CLS_NAN  : CLS_INF;
            default: cls = CLS_NORM;
        endcase
    end

endmodule

// File: rtl/f2b_round.sv
module f2b_round
    import f2b_pkg::*;
#(
    parameter int EXP_W      = 8,
    parameter int IN_FRAC_W  = 23,
    parameter int OUT_FRAC_W = 7
) (
    input  logic [EXP_W+IN_FRAC_W-1:0]  mag_in,
    input  rnd_mode_e                   mode,
    output logic [EXP_W+OUT_FRAC_W-1:0] mag_out,
    output logic                        lost,
    output logic                        to_inf
);

    localparam int DROP_W = IN_FRAC_W - OUT_FRAC_W;
    localparam int KEEP_W = EXP_W + OUT_FRAC_W;

    logic [KEEP_W-1:0] kept;
    logic [DROP_W-1:0] drop;
    logic              guard;
    logic              sticky;
    logic              bump;
    logic              jam;
    logic [KEEP_W:0]   sum;

    assign kept   = mag_in[EXP_W+IN_FRAC_W-1:DROP_W];
    assign drop   = mag_in[DROP_W-1:0];
    assign guard  = drop[DROP_W-1];
    assign sticky = |drop[DROP_W-2:0];
    assign lost   = |drop;

    always_comb begin
        unique case (mode)
            RM_TRUNC: begin
                bump = 1'b0;
                jam  = 1'b0;
            end
            RM_ODD: begin
                bump = 1'b0;
                jam  = lost;
            end
            RM_RNE, RM_RSVD: begin
                bump = guard & (sticky | kept[0]);
                jam  = 1'b0;
            end
        endcase
    end

    assign sum     = {1'b0, kept} + {{KEEP_W{1'b0}}, bump};
    assign mag_out = jam ? {kept[KEEP_W-1:1], 1'b1} : sum[KEEP_W-1:0];
    assign to_inf  = &mag_out[KEEP_W-1:OUT_FRAC_W];

endmodule

// File: rtl/f2b_pack.sv
module f2b_pack
    import f2b_pkg::*;
#(
    parameter int EXP_W      = 8,
    parameter int OUT_FRAC_W = 7
) (
    input  num_class_e                  cls,
    input  logic                        sign,
    input  logic [OUT_FRAC_W-1:0]       frac_hi,
    input  logic [EXP_W+OUT_FRAC_W-1:0] rounded,
    input  logic                        lost,
    input  logic                        to_inf,
    output logic [EXP_W+OUT_FRAC_W:0]   word,
    output logic                        inexact,
    output logic                        overflow
);

    localparam int KEEP_W = EXP_W + OUT_FRAC_W;

    always_comb begin
        word     = '0;
        inexact  = 1'b0;
        overflow = 1'b0;
        unique case (cls)
            CLS_ZERO, CLS_SUBN: begin
                word = {sign, {KEEP_W{1'b0}}};
            end
            CLS_NORM: begin
                word     = {sign, rounded};
                inexact  = lost;
                overflow = to_inf;
            end
            CLS_INF: begin
                word = {sign, {EXP_W{1'b1}}, {OUT_FRAC_W{1'b0}}};
            end
            CLS_NAN: begin
                word = {sign, {EXP_W{1'b1}}, 1'b1, frac_hi[OUT_FRAC_W-2:0]};
            end
            default: begin
                word = '0;
            end
        endcase
    end

endmodule

// File: rtl/f32_to_bf16_conv.sv
module f32_to_bf16_conv
    import f2b_pkg::*;
#(
    parameter int EXP_W      = 8,
    parameter int IN_FRAC_W  = 23,
    parameter int OUT_FRAC_W = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [EXP_W+IN_FRAC_W:0]    in_word,
    input  logic [1:0]                  rnd_mode,
    output logic                        out_valid,
    output logic [EXP_W+OUT_FRAC_W:0]   out_word,
    output logic                        flag_inexact,
    output logic                        flag_overflow
);

    localparam int IN_W   = EXP_W + IN_FRAC_W + 1;
    localparam int OUT_W  = EXP_W + OUT_FRAC_W + 1;
    localparam int KEEP_W = EXP_W + OUT_FRAC_W;

    logic                  sign_f;
    logic [EXP_W-1:0]      exp_f;
    logic [IN_FRAC_W-1:0]  frac_f;
    num_class_e            cls;
    logic [KEEP_W-1:0]     rounded;
    logic                  lost;
    logic                  to_inf;
    logic [OUT_W-1:0]      word_nxt;
    logic                  inexact_nxt;
    logic                  overflow_nxt;

    assign sign_f = in_word[IN_W-1];
    assign exp_f  = in_word[IN_W-2:IN_FRAC_W];
    assign frac_f = in_word[IN_FRAC_W-1:0];

    f2b_classify #(.EXP_W(EXP_W), .FRAC_W(IN_FRAC_W)) u_cls (
        .exp_f  (exp_f),
        .frac_f (frac_f),
        .cls    (cls)
    );

    f2b_round #(.EXP_W(EXP_W), .IN_FRAC_W(IN_FRAC_W), .OUT_FRAC_W(OUT_FRAC_W)) u_rnd (
        .mag_in  (in_word[IN_W-2:0]),
        .mode    (rnd_mode_e'(rnd_mode)),
        .mag_out (rounded),
        .lost    (lost),
        .to_inf  (to_inf)
    );

    f2b_pack #(.EXP_W(EXP_W), .OUT_FRAC_W(OUT_FRAC_W)) u_pack (
        .cls      (cls),
        .sign     (sign_f),
        .frac_hi  (frac_f[IN_FRAC_W-1:IN_FRAC_W-OUT_FRAC_W]),
        .rounded  (rounded),
        .lost     (lost),
        .to_inf   (to_inf),
        .word     (word_nxt),
        .inexact  (inexact_nxt),
        .overflow (overflow_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word      <= '0;
            flag_inexact  <= 1'b0;
            flag_overflow <= 1'b0;
        end else if (in_valid) begin
            out_word      <= word_nxt;
            flag_inexact  <= inexact_nxt;
            flag_overflow <= overflow_nxt;
        end
    end

endmodule

// File: rtl/f2b_checker.sv
module f2b_checker #(
    parameter int EXP_W      = 8,
    parameter int IN_FRAC_W  = 23,
    parameter int OUT_FRAC_W = 7
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [EXP_W+IN_FRAC_W:0]  in_word,
    input logic [1:0]                rnd_mode,
    input logic                      out_valid,
    input logic [EXP_W+OUT_FRAC_W:0] out_word,
    input logic                      flag_inexact,
    input logic                      flag_overflow
);

    localparam int IN_W   = EXP_W + IN_FRAC_W + 1;
    localparam int OUT_W  = EXP_W + OUT_FRAC_W + 1;
    localparam int DROP_W = IN_FRAC_W - OUT_FRAC_W;

    logic [EXP_W-1:0] e_in;
    logic             f_nz;
    logic             is_norm;

    assign e_in    = in_word[IN_W-2:IN_FRAC_W];
    assign f_nz    = |in_word[IN_FRAC_W-1:0];
    assign is_norm = (e_in != '0) && (e_in != '1);

    p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_trunc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rnd_mode == 2'b00 && is_norm)
        |=> out_word == $past(in_word[IN_W-1:DROP_W]));
    p_odd_lsb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rnd_mode == 2'b10 && is_norm && (|in_word[DROP_W-1:0]))
        |=> out_word[0] && !flag_overflow);
    p_ovf_inf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_overflow)
        |-> (out_word[OUT_W-2:0] == {{EXP_W{1'b1}}, {OUT_FRAC_W{1'b0}}}) && flag_inexact);
    p_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && e_in == '1 && !f_nz)
        |=> out_word == {$past(in_word[IN_W-1]), {EXP_W{1'b1}}, {OUT_FRAC_W{1'b0}}}
            && !flag_overflow && !flag_inexact);
    p_nan_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && e_in == '1 && f_nz)
        |=> out_word[OUT_W-2:OUT_FRAC_W-1] == '1 && !flag_overflow);
    p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && e_in == '0)
        |=> out_word[OUT_W-2:0] == '0 && !flag_inexact && !flag_overflow);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word) && $stable(flag_inexact) && $stable(flag_overflow));

endmodule

bind f32_to_bf16_conv f2b_checker #(
    .EXP_W      (EXP_W),
    .IN_FRAC_W  (IN_FRAC_W),
    .OUT_FRAC_W (OUT_FRAC_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_word       (in_word),
    .rnd_mode      (rnd_mode),
    .out_valid     (out_valid),
    .out_word      (out_word),
    .flag_inexact  (flag_inexact),
    .flag_overflow (flag_overflow)
);

// File: tb/sim_f32_to_bf16_conv.sv
module sim_f32_to_bf16_conv;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [1:0]  rnd_mode = '0;
    logic        out_valid;
    logic [15:0] out_word;
    logic        flag_inexact;
    logic        flag_overflow;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    f32_to_bf16_conv u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_word       (in_word),
        .rnd_mode      (rnd_mode),
        .out_valid     (out_valid),
        .out_word      (out_word),
        .flag_inexact  (flag_inexact),
        .flag_overflow (flag_overflow)
    );

    // entry: {mode[1:0], input[31:0], word[15:0], inexact, overflow, req[3:0]}
    localparam int NV = 28;
    localparam logic [55:0] VEC [NV] = '{
        {2'd0, 32'h3F80_0000, 16'h3F80, 1'b0, 1'b0, 4'd2},
        {2'd0, 32'h3F80_FFFF, 16'h3F80, 1'b1, 1'b0, 4'd2},
        {2'd0, 32'hC049_8000, 16'hC049, 1'b1, 1'b0, 4'd2},
        {2'd1, 32'h3F80_8000, 16'h3F80, 1'b1, 1'b0, 4'd3},
        {2'd1, 32'h3F81_8000, 16'h3F82, 1'b1, 1'b0, 4'd3},
        {2'd1, 32'h3F80_8001, 16'h3F81, 1'b1, 1'b0, 4'd3},
        {2'd1, 32'h3F80_7FFF, 16'h3F80, 1'b1, 1'b0, 4'd3},
        {2'd1, 32'h3FFF_8000, 16'h4000, 1'b1, 1'b0, 4'd3},
        {2'd2, 32'h3F80_0001, 16'h3F81, 1'b1, 1'b0, 4'd4},
        {2'd2, 32'h3F81_0000, 16'h3F81, 1'b0, 1'b0, 4'd4},
        {2'd2, 32'h3F80_8000, 16'h3F81, 1'b1, 1'b0, 4'd4},
        {2'd2, 32'h7F7F_FFFF, 16'h7F7F, 1'b1, 1'b0, 4'd4},
        {2'd3, 32'h3F81_8000, 16'h3F82, 1'b1, 1'b0, 4'd5},
        {2'd3, 32'h3F80_8000, 16'h3F80, 1'b1, 1'b0, 4'd5},
        {2'd1, 32'h7F7F_8000, 16'h7F80, 1'b1, 1'b1, 4'd6},
        {2'd1, 32'hFF7F_FFFF, 16'hFF80, 1'b1, 1'b1, 4'd6},
        {2'd0, 32'h7F7F_FFFF, 16'h7F7F, 1'b1, 1'b0, 4'd6},
        {2'd1, 32'h7F80_0000, 16'h7F80, 1'b0, 1'b0, 4'd7},
        {2'd2, 32'hFF80_0000, 16'hFF80, 1'b0, 1'b0, 4'd7},
        {2'd1, 32'h7F80_0001, 16'h7FC0, 1'b0, 1'b0, 4'd8},
        {2'd1, 32'hFFC1_0000, 16'hFFC1, 1'b0, 1'b0, 4'd8},
        {2'd0, 32'h7F81_0000, 16'h7FC1, 1'b0, 1'b0, 4'd8},
        {2'd2, 32'h0000_0000, 16'h0000, 1'b0, 1'b0, 4'd9},
        {2'd1, 32'h8000_0000, 16'h8000, 1'b0, 1'b0, 4'd9},
        {2'd1, 32'h0000_FFFF, 16'h0000, 1'b0, 1'b0, 4'd9},
        {2'd2, 32'h807F_FFFF, 16'h8000, 1'b0, 1'b0, 4'd9},
        {2'd1, 32'h0080_8000, 16'h0080, 1'b1, 1'b0, 4'd10},
        {2'd1, 32'h0080_0000, 16'h0080, 1'b0, 1'b0, 4'd10}
    };

    function automatic string req_name(input logic [3:0] n);
        case (n)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // drive on a falling edge, result registered at the next rising edge,
    // sampled on the falling edge after that
    task automatic apply(input logic [1:0] m, input logic [31:0] w);
        @(negedge clk);
        rnd_mode = m;
        in_word  = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            bad++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {out_valid, out_word, flag_inexact, flag_overflow}, 19'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {out_valid, out_word, flag_inexact, flag_overflow}, 19'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][55:54], VEC[i][53:22]);
            check(req_name(VEC[i][3:0]),
                  {out_valid, out_word, flag_inexact, flag_overflow},
                  {1'b1, VEC[i][21:4]});
        end

        // R1: strobe drops one cycle after a single pulse
        apply(2'd1, 32'h4049_0FDB);
        check("R1", {18'd0, out_valid}, 19'd1);
        @(negedge clk);
        check("R1", {18'd0, out_valid}, 19'd0);

        // R11: a word offered without the strobe leaves the outputs unchanged
        apply(2'd1, 32'h7F7F_8000);
        check("R6", {out_valid, out_word, flag_inexact, flag_overflow},
              {1'b1, 16'h7F80, 1'b1, 1'b1});
        rnd_mode = 2'd0;
        in_word  = 32'h3F80_0000;
        @(negedge clk);
        check("R11", {out_valid, out_word, flag_inexact, flag_overflow},
              {1'b0, 16'h7F80, 1'b1, 1'b1});

        // R10: flags clear again on an exact normal input
        apply(2'd2, 32'hBF80_0000);
        check("R10", {out_valid, out_word, flag_inexact, flag_overflow},
              {1'b1, 16'hBF80, 1'b0, 1'b0});

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule